// File: doc/BRIEF.md
# Register-Access SPI Slave

This block lets an external host reach a bank of 32 eight-bit registers over a four-wire serial link. The link uses SPI mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge. The host sends one 16-bit frame per chip-select window. The first byte carries a direction flag and a register address. For a write, the second byte carries the data. For a read, the slave shifts the register value out in that same second byte.

The slave runs entirely on the fast system clock. Serial clock, select and data-in pass through two-flop synchronisers, and edges are found in the system domain. A completed write produces a one-cycle strobe together with the address and data. Reads present an address to the register bank and take the value back on a combinational read-data input.

Address 0 is the data port: a write there pushes the transmit queue, and a read returns the head of the receive queue and pops it. Address 31 is a fixed revision code held inside the slave. A frame cut short by select rising has no side effect.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 bits sent MSB first while `csN` is low. Bit 15 is the direction (1 = write, 0 = read), bits 14:8 are a 7-bit address, and bits 7:0 are the write data (zero on a read).
- R2: During a read frame, `miso` is 0 for the first eight bits. The eight bits the host samples on rising edges 9 to 16 are the read value, MSB first.
- R3: For a read of addresses 1 to 30, the read value is the bank's `rdData` for the address presented on `rdAddr` (the low five address bits).
- R4: A complete write frame to addresses 1 to 30 produces exactly one `wrStb` pulse, one system clock wide, with `wrAddr` and `wrData` equal to the frame's address and data byte.
- R5: A complete write frame to address 0 produces exactly one `txPush` pulse carrying the data byte on `wrData`, and no `wrStb`.
- R6: A complete read frame to address 0 returns `rdData` for address 0 and produces exactly one `rdPop` pulse after the frame. Reads of other addresses never pulse `rdPop`.
- R7: A read of address 31 returns the parameter `REV_ID` (default 0xA1). A write to address 31 produces no strobe.
- R8: Addresses 32 to 127 read as 0x00, and writes to them produce no strobe.
- R9: If `csN` rises before the 16th rising edge, the frame produces no `wrStb`, `txPush` or `rdPop`.
- R10: After reset, and whenever `csN` is high, `miso` is 0 and all strobes are low.
- R11: At most one of `wrStb`, `txPush` and `rdPop` is high in any cycle, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host (mode 0) |
| csN | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| rdAddr | output | 5 | Register address presented to the bank for reads |
| rdData | input | 8 | Bank read value for `rdAddr` (combinational) |
| wrStb | output | 1 | One-cycle register write strobe |
| wrAddr | output | 5 | Register address of the last write |
| wrData | output | 8 | Data byte of the last write or push |
| txPush | output | 1 | One-cycle transmit-queue push (write to address 0) |
| rdPop | output | 1 | One-cycle receive-queue pop (read of address 0) |

## Verification
The bench reads and writes every one of the 128 address codes. This catches a decoder that aliases the upper address bits onto the bank, since such a design would strobe or return bank data for addresses 32 and above. It also catches a decoder that lets a write reach the fixed revision code. The bench samples `miso` just before each rising edge in both bytes. A load that comes one falling edge late, or a shift that starts on the eighth falling edge, would lose or duplicate the read MSB. The bench also truncates write and data-port read frames part way through, which exposes a design that commits on header latch rather than on frame completion. It counts strobe pulses per frame, so a doubled or missing pulse, or a push that also raises `wrStb`, is reported.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 8;
  localparam int DATA_W     = 8;
  localparam int FIELD_AW   = 7;
  localparam int REG_AW     = 5;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int NUM_REGS   = 1 << REG_AW;

  typedef struct packed {
    logic shiftIn;   // rising edge, capture mosi bit
    logic latchHdr;  // this rising edge completes the header byte
    logic loadRd;    // load read value into output shifter
    logic shiftOut;  // falling edge inside second byte
    logic finish;    // this rising edge completes the frame
    logic clear;     // select inactive
  } ctlStb_t;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output logic    mosiBit,
  output ctlStb_t stb
);
  logic [2:0]       sclkSync;
  logic [1:0]       csSync;
  logic [1:0]       mosiSync;
  logic [CNT_W-1:0] bitCnt;
  logic             loadQ;
  logic             sRise, sFall, csActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign sRise    = sclkSync[1] & ~sclkSync[2];
  assign sFall    = ~sclkSync[1] & sclkSync[2];
  assign csActive = ~csSync[1];
  assign mosiBit  = mosiSync[1];

  always_comb begin
    stb          = '0;
    stb.clear    = ~csActive;
    stb.shiftIn  = csActive & sRise & (bitCnt < CNT_W'(FRAME_BITS));
    stb.latchHdr = stb.shiftIn & (bitCnt == CNT_W'(HDR_BITS - 1));
    stb.finish   = stb.shiftIn & (bitCnt == CNT_W'(FRAME_BITS - 1));
    stb.shiftOut = csActive & sFall & (bitCnt > CNT_W'(HDR_BITS))
                   & (bitCnt < CNT_W'(FRAME_BITS));
    stb.loadRd   = loadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      loadQ  <= 1'b0;
    end else begin
      loadQ <= stb.latchHdr & csActive;
      if (!csActive)       bitCnt <= '0;
      else if (stb.shiftIn) bitCnt <= bitCnt + 1'b1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS));
  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (bitCnt == '0));
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID = 8'hA1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] rdData,
  output logic [REG_AW-1:0] rdAddr,
  output logic              miso,
  output logic              wrStb,
  output logic [REG_AW-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              txPush,
  output logic              rdPop
);
  localparam logic [FIELD_AW-1:0] DATA_PORT = '0;
  localparam logic [FIELD_AW-1:0] REV_ADDR  = FIELD_AW'(NUM_REGS - 1);

  logic [DATA_W-2:0]   rxShift;
  logic [DATA_W-1:0]   nextByte;
  logic [DATA_W-1:0]   txShift;
  logic [DATA_W-1:0]   readVal;
  logic [FIELD_AW-1:0] addrQ;
  logic                isWrite;
  logic                inBank, isPort, isRev;

  assign nextByte = {rxShift, mosiBit};
  assign inBank   = addrQ < FIELD_AW'(NUM_REGS);
  assign isPort   = addrQ == DATA_PORT;
  assign isRev    = addrQ == REV_ADDR;
  assign rdAddr   = addrQ[REG_AW-1:0];
  assign miso     = txShift[DATA_W-1];

  always_comb begin
    if (isWrite || !inBank) readVal = '0;
    else if (isRev)         readVal = REV_ID;
    else                    readVal = rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addrQ   <= '0;
      isWrite <= 1'b0;
      txShift <= '0;
      wrStb   <= 1'b0;
      txPush  <= 1'b0;
      rdPop   <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrStb  <= 1'b0;
      txPush <= 1'b0;
      rdPop  <= 1'b0;
      if (stb.shiftIn) rxShift <= nextByte[DATA_W-2:0];
      if (stb.latchHdr) begin
        isWrite <= nextByte[DATA_W-1];
        addrQ   <= nextByte[FIELD_AW-1:0];
      end
      if (stb.clear)         txShift <= '0;
      else if (stb.loadRd)   txShift <= readVal;
      else if (stb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.finish) begin
        wrStb  <= isWrite & inBank & !isPort & !isRev;
        txPush <= isWrite & isPort;
        rdPop  <= !isWrite & isPort;
        if (isWrite && inBank && !isRev) begin
          wrAddr <= addrQ[REG_AW-1:0];
          wrData <= nextByte;
        end
      end
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStb, txPush, rdPop}));
  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);
  // R7
  wr_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (wrAddr != '0) && (wrAddr != REG_AW'(NUM_REGS - 1)));
  // R10
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !miso);
  // R2
  early_miso_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchHdr |-> !miso);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'hA1
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic [4:0] rdAddr,
  input  logic [7:0] rdData,
  output logic       wrStb,
  output logic [4:0] wrAddr,
  output logic [7:0] wrData,
  output logic       txPush,
  output logic       rdPop
);
  ctlStb_t stb;
  logic    mosiBit;

  spi_reg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .mosiBit(mosiBit), .stb(stb)
  );

  spi_reg_dp #(.REV_ID(REV_ID)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiBit(mosiBit),
    .rdData(rdData), .rdAddr(rdAddr), .miso(miso),
    .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .txPush(txPush), .rdPop(rdPop)
  );
endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, wrStb, txPush, rdPop;
  logic [4:0] rdAddr, wrAddr;
  logic [7:0] rdData, wrData;
  int compared = 0, mismatched = 0;
  int wrCnt = 0, pushCnt = 0, popCnt = 0;
  logic [4:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0, lastPushData = '0;
  localparam logic [7:0] REV = 8'hA1;

  always #2 clk = ~clk;

  function automatic logic [7:0] bankVal(input logic [4:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction
  assign rdData = bankVal(rdAddr);

  spi_reg_slave #(.REV_ID(REV)) dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .rdAddr(rdAddr), .rdData(rdData), .wrStb(wrStb),
    .wrAddr(wrAddr), .wrData(wrData), .txPush(txPush), .rdPop(rdPop)
  );

  always @(posedge clk) begin
    if (wrStb)  begin wrCnt++; lastWrAddr <= wrAddr; lastWrData <= wrData; end
    if (txPush) begin pushCnt++; lastPushData <= wrData; end
    if (rdPop)  popCnt++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // host side, mode 0; each SCLK half period is 8 system clocks
  task automatic xfer(input logic [15:0] w, input int nbits,
                      output logic [7:0] hiByte, output logic [7:0] loByte);
    hiByte = '0; loByte = '0;
    @(negedge clk); csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      repeat (8) @(negedge clk);
      if (i < 8) hiByte = {hiByte[6:0], miso};
      else       loByte = {loByte[6:0], miso};
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] hi, lo, expv;
    int w0, p0, q0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(miso == 1'b0 && !wrStb && !txPush && !rdPop, "R10", int'(miso), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(miso == 1'b0, "R10", int'(miso), 0);

    // R2 R3 R6 R7 R8: read every address code
    for (int a = 0; a < 128; a++) begin
      p0 = popCnt; w0 = wrCnt;
      xfer({1'b0, 7'(a), 8'h00}, 16, hi, lo);
      if (a >= 32)      expv = 8'h00;
      else if (a == 31) expv = REV;
      else              expv = bankVal(5'(a));
      check(hi == 8'h00, "R2", hi, 0);
      if (a == 0)       check(lo == expv, "R6", lo, expv);
      else if (a == 31) check(lo == expv, "R7", lo, expv);
      else if (a >= 32) check(lo == expv, "R8", lo, expv);
      else              check(lo == expv, "R3", lo, expv);
      check(popCnt - p0 == (a == 0 ? 1 : 0), "R6", popCnt - p0, a == 0 ? 1 : 0);
      check(wrCnt == w0, "R11", wrCnt - w0, 0);
      check(miso == 1'b0, "R10", int'(miso), 0);
    end

    // R1 R4 R5 R7 R8: write every address code
    for (int a = 0; a < 128; a++) begin
      logic [7:0] d;
      d = 8'((a * 3 + 1) ^ 8'h96);
      w0 = wrCnt; p0 = pushCnt; q0 = popCnt;
      xfer({1'b1, 7'(a), d}, 16, hi, lo);
      check(q0 == popCnt, "R6", popCnt - q0, 0);
      if (a == 0) begin
        check(pushCnt - p0 == 1 && wrCnt == w0, "R5", pushCnt - p0, 1);
        check(lastPushData == d, "R5", lastPushData, d);
      end else if (a == 31 || a >= 32) begin
        check(wrCnt == w0 && pushCnt == p0, a == 31 ? "R7" : "R8", wrCnt - w0, 0);
      end else begin
        check(wrCnt - w0 == 1 && pushCnt == p0, "R4", wrCnt - w0, 1);
        check(lastWrAddr == 5'(a) && lastWrData == d, "R1",
              {lastWrAddr, lastWrData}, {5'(a), d});
      end
    end

    // R9: truncated frames
    for (int n = 1; n < 16; n++) begin
      w0 = wrCnt; p0 = pushCnt; q0 = popCnt;
      xfer({1'b1, 7'h05, 8'h3C}, n, hi, lo);
      check(wrCnt == w0, "R9", wrCnt - w0, 0);
      xfer({1'b1, 7'h00, 8'h3C}, n, hi, lo);
      check(pushCnt == p0, "R9", pushCnt - p0, 0);
      xfer({1'b0, 7'h00, 8'h00}, n, hi, lo);
      check(popCnt == q0, "R9", popCnt - q0, 0);
    end
    // a full frame still works after truncation
    w0 = wrCnt;
    xfer({1'b1, 7'h0A, 8'h5E}, 16, hi, lo);
    check(wrCnt - w0 == 1 && lastWrData == 8'h5E, "R4", lastWrData, 8'h5E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule